// File: doc/BRIEF.md
# ATA Soft Reset and Device Probe Sequencer

This block runs the bus-level software reset and the device detection routine of a parallel ATA port. It has no timing engine for the bus itself. Instead it drives a simple register-access port: it presents one 8-bit register read or write, holds it until the access engine acknowledges it, and only then moves to the next step. A single `start` pulse launches the whole routine. The block first checks which of the two devices answer a scratch-register test. It then pulses the reset bit of the device-control register and waits until the devices report that they are no longer busy.

Wall-clock waits are counted from a `tick` input, so the integrator chooses the time base. A programmable deadline bounds the readiness phase. When the routine ends, the block raises a one-cycle `done` pulse and reports a two-bit presence mask. An error flag is set only when the deadline runs out.

Top module: `ata_srst_ctrl`

## Requirements
- R1: For each probed device, the block writes the device register (register code 4'h6) with 8'hA0 for device 0 or 8'hB0 for device 1. It then writes sector count (code 4'h2) and LBA low (code 4'h3) alternately, starting with sector count, using the data values 55,AA then AA,55 then 55,AA. After that it reads sector count and then LBA low.
- R2: A probed device is marked present (bit 0 of `dev_present` for device 0, bit 1 for device 1) only when the sector-count readback is 8'h55 and the LBA-low readback is 8'hAA.
- R3: When `slave_ok` is low, device 1 is neither probed nor waited on, and `dev_present[1]` stays 0.
- R4: After probing, the block writes 8'hA0 to the device register. It then writes the control register (code 4'hE) three times: `ctl_base` with bit 2 cleared, then the same value with bit 2 set, then the cleared value again. At least RST_TICKS ticks separate consecutive control writes.
- R5: After the reset, the block always reads the status register (code 4'h7) of device 0. It repeats the read while bit 7 (busy) is set.
- R6: A status read of 8'hFF during the device-0 wait ends the routine at once. The block pulses `done`, leaves `err` low, clears `dev_present`, and issues no further access.
- R7: When device 1 was found, the block writes 8'hB0 to the device register. It then reads sector count and LBA low up to two times, until both read 8'h01. Each failed attempt is followed by a wait of at least GAP_TICKS ticks. Finally it polls device 1's status until busy clears. A status of 8'hFF there clears `dev_present[1]`.
- R8: A routine that is not cut short ends with three device-register writes: 8'hA0, 8'hB0, 8'hA0.
- R9: Once the readiness phase has run for `dl_ticks` ticks, the block stops before its next access. It sets `err`, pulses `done`, and issues no further access.
- R10: A register request stays asserted with stable register code, data and direction until it is acknowledged, and drops in the cycle after the acknowledge.
- R11: `done` lasts one cycle. It rises in the cycle after the last acknowledge. A `start` pulse while the routine is running is ignored.
- R12: Out of reset, `acc_req`, `done`, `err` and `dev_present` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches the routine when idle |
| slave_ok | input | 1 | Allows probing and waiting for device 1 |
| ctl_base | input | 8 | Base value for device-control writes |
| dl_ticks | input | DL_W | Deadline in ticks for the readiness phase |
| tick | input | 1 | Time base strobe |
| acc_req | output | 1 | Register access request |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_reg | output | 4 | Register code: bit 3 picks the control block, bits 2:0 the address |
| acc_wdata | output | 8 | Write data |
| acc_ack | input | 1 | Access complete, one cycle |
| acc_rdata | input | 8 | Read data, valid with acc_ack |
| dev_present | output | 2 | Presence mask, final at done |
| done | output | 1 | End-of-routine pulse |
| err | output | 1 | Deadline expired, held until next start |

## Verification
Each access is issued two cycles after the acknowledge of the previous one, or after a wait for the timed steps. `done` is due in the cycle that follows the final acknowledge. The bench's device model answers at the falling edge after a random latency of zero to two cycles. It logs every access together with a running tick count. The log is compared with a sequence that the bench derives from the requirements, and the tick stamps bound each timed gap from below and above. Outputs are sampled on falling edges only: `done` is checked for its one-cycle width, and the port is watched for silence after the routine ends.

// File: rtl/ata_srst_pkg.sv
package ata_srst_pkg;

   localparam logic [3:0] RG_NSECT = 4'h2;
   localparam logic [3:0] RG_LBAL  = 4'h3;
   localparam logic [3:0] RG_DEV   = 4'h6;
   localparam logic [3:0] RG_STAT  = 4'h7;
   localparam logic [3:0] RG_CTL   = 4'hE;

   localparam logic [7:0] SEL_D0   = 8'hA0;
   localparam logic [7:0] SEL_D1   = 8'hB0;
   localparam logic [7:0] PAT_A    = 8'h55;
   localparam logic [7:0] PAT_B    = 8'hAA;
   localparam logic [7:0] RST_BIT  = 8'h04;
   localparam logic [7:0] FLOAT_V  = 8'hFF;
   localparam logic [7:0] SIG_ONE  = 8'h01;

   typedef enum logic [2:0] {
      PH_PROBE, PH_SEL0, PH_RST, PH_WAIT0,
      PH_D1SEL, PH_D1POLL, PH_WAIT1, PH_FIN
   } phase_t;

   typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_DLY = 2'd2} op_kind_t;

   typedef struct packed {
      op_kind_t   kind;
      logic [3:0] rg;
      logic [7:0] data;
      logic       gap;
   } op_t;

   // Step program: phase and index select one register access or wait.
   function automatic op_t op_lookup(input phase_t ph, input logic [3:0] idx,
                                     input logic dev, input logic [7:0] base);
      op_t  o;
      logic swap;
      o    = '{kind: OP_WR, rg: RG_DEV, data: SEL_D0, gap: 1'b0};
      swap = (idx == 4'd3) || (idx == 4'd4);
      case (ph)
         PH_PROBE: begin
            if (idx == 4'd0) begin
               o.data = dev ? SEL_D1 : SEL_D0;
            end else if (idx <= 4'd6) begin
               o.rg   = idx[0] ? RG_NSECT : RG_LBAL;
               o.data = (idx[0] ^ swap) ? PAT_A : PAT_B;
            end else begin
               o.kind = OP_RD;
               o.rg   = (idx == 4'd7) ? RG_NSECT : RG_LBAL;
            end
         end
         PH_RST: begin
            o.rg = RG_CTL;
            if (idx == 4'd1 || idx == 4'd3) o.kind = OP_DLY;
            else if (idx == 4'd2)           o.data = base | RST_BIT;
            else                            o.data = base & ~RST_BIT;
         end
         PH_WAIT0, PH_WAIT1: begin
            o.kind = OP_RD;
            o.rg   = RG_STAT;
         end
         PH_D1SEL: o.data = SEL_D1;
         PH_D1POLL: begin
            if (idx == 4'd0) begin
               o.kind = OP_RD;
               o.rg   = RG_NSECT;
            end else if (idx == 4'd1) begin
               o.kind = OP_RD;
               o.rg   = RG_LBAL;
            end else begin
               o.kind = OP_DLY;
               o.gap  = 1'b1;
            end
         end
         PH_FIN: o.data = (idx == 4'd1) ? SEL_D1 : SEL_D0;
         default: o.data = SEL_D0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/ata_srst_port.sv
module ata_srst_port
   import ata_srst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue,
   input  logic       issue_wr,
   input  logic [3:0] issue_reg,
   input  logic [7:0] issue_data,
   input  logic       acc_ack,
   output logic       acc_req,
   output logic       acc_wr,
   output logic [3:0] acc_reg,
   output logic [7:0] acc_wdata,
   output logic       op_done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_req   <= 1'b0;
         acc_wr    <= 1'b0;
         acc_reg   <= RG_DEV;
         acc_wdata <= '0;
      end else if (issue) begin
         acc_req   <= 1'b1;
         acc_wr    <= issue_wr;
         acc_reg   <= issue_reg;
         acc_wdata <= issue_data;
      end else if (acc_req && acc_ack) begin
         acc_req   <= 1'b0;
      end
   end

   assign op_done = acc_req & acc_ack;

endmodule

// File: rtl/ata_srst_tick_timer.sv
module ata_srst_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   input  logic         tick,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (load)             cnt <= len;
      else if (tick && cnt != 0) cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/ata_srst_deadline.sv
module ata_srst_deadline #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (clr)                        cnt <= '0;
      else if (run && tick && cnt < limit) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt >= limit);

endmodule

// File: rtl/ata_srst_ctrl.sv
module ata_srst_ctrl
   import ata_srst_pkg::*;
#(
   parameter int RST_TICKS = 20,
   parameter int GAP_TICKS = 50,
   parameter int DL_W      = 16,
   parameter int DEV1_EN   = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            slave_ok,
   input  logic [7:0]      ctl_base,
   input  logic [DL_W-1:0] dl_ticks,
   input  logic            tick,
   output logic            acc_req,
   output logic            acc_wr,
   output logic [3:0]      acc_reg,
   output logic [7:0]      acc_wdata,
   input  logic            acc_ack,
   input  logic [7:0]      acc_rdata,
   output logic [1:0]      dev_present,
   output logic            done,
   output logic            err
);

   localparam int T_MAX = (RST_TICKS > GAP_TICKS) ? RST_TICKS : GAP_TICKS;
   localparam int TW    = $clog2(T_MAX + 1);

   generate
      if (RST_TICKS < 1 || GAP_TICKS < 1) begin : g_bad_len
         $error("wait lengths must be at least one tick");
      end
      if (DL_W < 2 || DL_W > 32) begin : g_bad_dl
         $error("deadline width out of range");
      end
   endgenerate

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ACC, ST_DLY} state_t;

   state_t     state;
   phase_t     phase, nxt_phase;
   logic [3:0] idx, nxt_idx;
   logic       dev_q, nxt_dev;
   logic       try_q, nxt_try;
   logic [7:0] nsect_q, nxt_nsect;
   logic [1:0] mask_q, nxt_mask;
   logic       done_q, err_q;
   logic       finish, dl_start;
   logic       slave_en;
   logic       op_done, tmr_exp, dl_exp;
   logic       running;
   op_t        op;

   generate
      if (DEV1_EN != 0) begin : g_dev1
         assign slave_en = slave_ok;
      end else begin : g_single
         assign slave_en = slave_ok & 1'b0;
      end
   endgenerate

   assign op = op_lookup(phase, idx, dev_q, ctl_base);

   logic dl_phase, abort, adv, issue, tmr_load;
   assign dl_phase = (phase == PH_WAIT0) || (phase == PH_D1SEL) ||
                     (phase == PH_D1POLL) || (phase == PH_WAIT1);
   assign abort    = dl_phase && dl_exp && (state == ST_RUN || state == ST_DLY);
   assign adv      = (state == ST_ACC && op_done) || (state == ST_DLY && tmr_exp && !abort);
   assign issue    = (state == ST_RUN) && !abort && (op.kind != OP_DLY);
   assign tmr_load = (state == ST_RUN) && !abort && (op.kind == OP_DLY);
   assign running  = (state != ST_IDLE);

   ata_srst_port u_port (
      .clk(clk), .rst_n(rst_n), .issue(issue), .issue_wr(op.kind == OP_WR),
      .issue_reg(op.rg), .issue_data(op.data), .acc_ack(acc_ack),
      .acc_req(acc_req), .acc_wr(acc_wr), .acc_reg(acc_reg),
      .acc_wdata(acc_wdata), .op_done(op_done)
   );

   ata_srst_tick_timer #(.W(TW)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(tmr_load),
      .len(op.gap ? TW'(GAP_TICKS) : TW'(RST_TICKS)),
      .tick(tick), .expired(tmr_exp)
   );

   ata_srst_deadline #(.W(DL_W)) u_dl (
      .clk(clk), .rst_n(rst_n), .clr(dl_start & adv), .run(dl_phase),
      .tick(tick), .limit(dl_ticks), .expired(dl_exp)
   );

   // Next step, evaluated when the current step completes.
   always_comb begin
      nxt_phase = phase;
      nxt_idx   = idx;
      nxt_dev   = dev_q;
      nxt_try   = try_q;
      nxt_nsect = nsect_q;
      nxt_mask  = mask_q;
      finish    = 1'b0;
      dl_start  = 1'b0;
      case (phase)
         PH_PROBE: begin
            if (idx == 4'd7) nxt_nsect = acc_rdata;
            if (idx != 4'd8) begin
               nxt_idx = idx + 4'd1;
            end else begin
               nxt_mask[dev_q] = (nsect_q == PAT_A) && (acc_rdata == PAT_B);
               nxt_idx = 4'd0;
               if (!dev_q && slave_en) begin
                  nxt_dev = 1'b1;
               end else begin
                  nxt_dev   = 1'b0;
                  nxt_phase = PH_SEL0;
               end
            end
         end
         PH_SEL0: begin
            nxt_phase = PH_RST;
            nxt_idx   = 4'd0;
         end
         PH_RST: begin
            if (idx != 4'd4) begin
               nxt_idx = idx + 4'd1;
            end else begin
               nxt_phase = PH_WAIT0;
               nxt_idx   = 4'd0;
               dl_start  = 1'b1;
            end
         end
         PH_WAIT0: begin
            if (acc_rdata == FLOAT_V) begin
               nxt_mask = 2'b00;
               finish   = 1'b1;
            end else if (!acc_rdata[7]) begin
               nxt_phase = mask_q[1] ? PH_D1SEL : PH_FIN;
            end
         end
         PH_D1SEL: begin
            nxt_phase = PH_D1POLL;
            nxt_idx   = 4'd0;
            nxt_try   = 1'b0;
         end
         PH_D1POLL: begin
            if (idx == 4'd0) begin
               nxt_nsect = acc_rdata;
               nxt_idx   = 4'd1;
            end else if (idx == 4'd1) begin
               if (nsect_q == SIG_ONE && acc_rdata == SIG_ONE) begin
                  nxt_phase = PH_WAIT1;
                  nxt_idx   = 4'd0;
               end else begin
                  nxt_idx = 4'd2;
               end
            end else begin
               nxt_idx = 4'd0;
               if (try_q) nxt_phase = PH_WAIT1;
               else       nxt_try   = 1'b1;
            end
         end
         PH_WAIT1: begin
            if (acc_rdata == FLOAT_V) begin
               nxt_mask[1] = 1'b0;
               nxt_phase   = PH_FIN;
            end else if (!acc_rdata[7]) begin
               nxt_phase = PH_FIN;
            end
         end
         PH_FIN: begin
            if (idx != 4'd2) nxt_idx = idx + 4'd1;
            else             finish  = 1'b1;
         end
         default: finish = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         phase   <= PH_PROBE;
         idx     <= '0;
         dev_q   <= 1'b0;
         try_q   <= 1'b0;
         nsect_q <= '0;
         mask_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_RUN;
                  phase  <= PH_PROBE;
                  idx    <= '0;
                  dev_q  <= 1'b0;
                  try_q  <= 1'b0;
                  mask_q <= '0;
                  err_q  <= 1'b0;
               end
            end
            ST_RUN: begin
               if (abort) begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (op.kind == OP_DLY) begin
                  state <= ST_DLY;
               end else begin
                  state <= ST_ACC;
               end
            end
            default: begin
               if (abort) begin
                  err_q  <= 1'b1;
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end else if (adv) begin
                  phase   <= nxt_phase;
                  idx     <= nxt_idx;
                  dev_q   <= nxt_dev;
                  try_q   <= nxt_try;
                  nsect_q <= nxt_nsect;
                  mask_q  <= nxt_mask;
                  if (finish) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_RUN;
                  end
               end
            end
         endcase
      end
   end

   assign dev_present = mask_q;
   assign done        = done_q;
   assign err         = err_q;

endmodule

// File: rtl/ata_srst_chk.sv
module ata_srst_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_req,
   input logic       acc_ack,
   input logic       acc_wr,
   input logic [3:0] acc_reg,
   input logic [7:0] acc_wdata,
   input logic       done,
   input logic       err,
   input logic       running
);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && !acc_ack |=> acc_req && $stable(acc_reg) && $stable(acc_wdata) && $stable(acc_wr));

   p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && acc_ack |=> !acc_req);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !running && !acc_req);

   p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !acc_req);

endmodule

bind ata_srst_ctrl ata_srst_chk u_chk (
   .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_ack(acc_ack),
   .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
   .done(done), .err(err), .running(running)
);

// File: tb/tb_ata_srst_ctrl.sv
module tb_ata_srst_ctrl;

   localparam int RST_T = 20;
   localparam int GAP_T = 50;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        slave_ok = 1'b0;
   logic [7:0]  ctl_base = 8'h00;
   logic [15:0] dl_ticks = 16'd3000;
   logic        tick = 1'b0;
   logic        acc_req, acc_wr;
   logic [3:0]  acc_reg;
   logic [7:0]  acc_wdata;
   logic        acc_ack = 1'b0;
   logic [7:0]  acc_rdata = 8'h00;
   logic [1:0]  dev_present;
   logic        done, err;

   ata_srst_ctrl #(.RST_TICKS(RST_T), .GAP_TICKS(GAP_T), .DL_W(16), .DEV1_EN(1)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .slave_ok(slave_ok),
      .ctl_base(ctl_base), .dl_ticks(dl_ticks), .tick(tick),
      .acc_req(acc_req), .acc_wr(acc_wr), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
      .acc_ack(acc_ack), .acc_rdata(acc_rdata), .dev_present(dev_present),
      .done(done), .err(err)
   );

   always #2 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc = 0, tk = 0;

   // device model state
   bit       live [2];
   bit       sig1, drop1, hang0, srst_seen, sel;
   int       bcnt [2], busy_n [2];
   bit [7:0] ns [2], lb [2];

   // observed and expected access logs
   bit       lg_w [128];  bit [3:0] lg_r [128];  bit [7:0] lg_d [128];  int lg_t [128];
   int       n_log;
   bit       ex_w [128];  bit [3:0] ex_r [128];  bit [7:0] ex_d [128];  bit ex_gap [128];
   int       n_ex, n_pref, i_ctl;
   bit [1:0] ex_mask;
   bit       ex_err;

   task automatic chk(string rq, string what, int act, int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
      end
   endtask

   function automatic bit [7:0] model_access(bit w, bit [3:0] r, bit [7:0] d);
      bit [7:0] v = 8'hFF;
      if (w) begin
         if (r == 4'h6) sel = d[4];
         else if (r == 4'h2 && live[sel]) ns[sel] = d;
         else if (r == 4'h3 && live[sel]) lb[sel] = d;
         else if (r == 4'hE) begin
            if (d[2]) srst_seen = 1'b1;
            else if (srst_seen) begin
               srst_seen = 1'b0;
               for (int k = 0; k < 2; k++) begin
                  bcnt[k] = busy_n[k];
                  ns[k] = (k == 1 && !sig1) ? 8'h00 : 8'h01;
                  lb[k] = ns[k];
               end
               if (drop1) live[1] = 1'b0;
            end
         end
         return 8'h00;
      end
      if (!live[sel]) return 8'hFF;
      if (r == 4'h2) v = ns[sel];
      else if (r == 4'h3) v = lb[sel];
      else if (r == 4'h7) begin
         if (hang0 && sel == 1'b0) v = 8'h80;
         else if (bcnt[sel] > 0) begin bcnt[sel]--; v = 8'h80; end
         else v = 8'h50;
      end
      return v;
   endfunction

   // access responder
   initial begin
      forever begin
         @(negedge clk);
         if (acc_req) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            acc_rdata = model_access(acc_wr, acc_reg, acc_wdata);
            if (n_log < 128) begin
               lg_w[n_log] = acc_wr; lg_r[n_log] = acc_reg;
               lg_d[n_log] = acc_wdata; lg_t[n_log] = tk;
            end
            n_log++;
            acc_ack = 1'b1;
            @(negedge clk);
            acc_ack = 1'b0;
         end
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         tick = ($urandom % 3) != 0;
         if (tick) tk++;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   task automatic push(bit w, bit [3:0] r, bit [7:0] d);
      ex_w[n_ex] = w; ex_r[n_ex] = r; ex_d[n_ex] = d; ex_gap[n_ex] = 1'b0;
      n_ex++;
   endtask

   // expected sequence from the requirements
   task automatic build(bit p0, bit p1, bit slv, bit s1, bit dr1, int b0, int b1, bit h0, bit [7:0] base);
      bit m1;
      n_ex = 0;
      for (int d = 0; d < (slv ? 2 : 1); d++) begin
         push(1, 4'h6, d ? 8'hB0 : 8'hA0);                         // R1
         push(1, 4'h2, 8'h55); push(1, 4'h3, 8'hAA);
         push(1, 4'h2, 8'hAA); push(1, 4'h3, 8'h55);
         push(1, 4'h2, 8'h55); push(1, 4'h3, 8'hAA);
         push(0, 4'h2, 0);     push(0, 4'h3, 0);
      end
      m1 = slv && p1;                                                // R2 R3
      ex_mask = {m1, p0};
      ex_err  = 1'b0;
      push(1, 4'h6, 8'hA0);                                          // R4
      i_ctl = n_ex;
      push(1, 4'hE, base & 8'hFB); push(1, 4'hE, base | 8'h04); push(1, 4'hE, base & 8'hFB);
      push(0, 4'h7, 0);                                              // R5
      n_pref = n_ex;
      if (!p0) begin ex_mask = 2'b00; return; end                    // R6
      if (h0) begin ex_err = 1'b1; return; end                       // R9
      repeat (b0) push(0, 4'h7, 0);
      if (m1) begin                                                  // R7
         push(1, 4'h6, 8'hB0);
         push(0, 4'h2, 0); push(0, 4'h3, 0);
         if (!s1 || dr1) begin
            ex_gap[n_ex-1] = 1'b1;
            push(0, 4'h2, 0); push(0, 4'h3, 0);
            ex_gap[n_ex-1] = 1'b1;
         end
         if (dr1) begin push(0, 4'h7, 0); ex_mask[1] = 1'b0; end
         else repeat (b1 + 1) push(0, 4'h7, 0);
      end
      push(1, 4'h6, 8'hA0); push(1, 4'h6, 8'hB0); push(1, 4'h6, 8'hA0);   // R8
   endtask

   task automatic run_case(string nm, bit p0, bit p1, bit slv, bit s1, bit dr1, int b0, int b1,
                           bit h0, bit [7:0] base, int dl, bit extra);
      int w, bad, seen, cmp_n;
      live[0] = p0; live[1] = p1; sig1 = s1; drop1 = dr1; hang0 = h0;
      busy_n[0] = b0; busy_n[1] = b1; bcnt[0] = 0; bcnt[1] = 0;
      ns[0] = 0; ns[1] = 0; lb[0] = 0; lb[1] = 0; sel = 0; srst_seen = 0;
      n_log = 0;
      build(p0, p1, slv, s1, dr1, b0, b1, h0, base);
      ctl_base = base; slave_ok = slv; dl_ticks = 16'(dl);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (extra) begin
         repeat (30) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;             // R11 ignored
      end
      w = 0;
      while (!done && w < 20000) begin @(negedge clk); w++; end
      chk("R11", {nm, " done seen"}, done, 1);
      chk(h0 ? "R9" : "R2", {nm, " presence mask"}, dev_present, ex_mask);
      chk("R9", {nm, " error flag"}, err, ex_err);
      seen = n_log;
      @(negedge clk);
      chk("R11", {nm, " done width"}, done, 0);
      repeat (40) @(negedge clk);
      chk("R6", {nm, " no access after done"}, n_log, seen);
      // log comparison
      cmp_n = h0 ? n_pref : n_ex;
      if (!h0) chk("R1", {nm, " access count"}, n_log, n_ex);
      else chk("R9", {nm, " reached status poll"}, int'(n_log >= n_pref), 1);
      bad = -1;
      for (int i = 0; i < cmp_n && i < n_log && i < 128; i++)
         if (bad < 0 && (lg_w[i] != ex_w[i] || lg_r[i] != ex_r[i] || (ex_w[i] && lg_d[i] != ex_d[i])))
            bad = i;
      if (h0)
         for (int i = n_pref; i < n_log && i < 128; i++)
            if (bad < 0 && (lg_w[i] || lg_r[i] != 4'h7)) bad = i;
      if (bad >= 0)
         chk("R1", {nm, " access sequence"}, {lg_w[bad], 3'b0, lg_r[bad], lg_d[bad]},
             {ex_w[bad], 3'b0, ex_r[bad], ex_d[bad]});
      else chk("R8", {nm, " access sequence"}, 0, 0);
      if (n_log >= i_ctl + 3) begin
         for (int k = 0; k < 2; k++) begin
            int dt = lg_t[i_ctl+k+1] - lg_t[i_ctl+k];
            chk("R4", {nm, " reset wait"}, int'(dt >= RST_T && dt <= RST_T + 8), 1);
         end
      end
      if (!h0 && bad < 0)
         for (int i = 0; i + 1 < n_ex; i++)
            if (ex_gap[i]) chk("R7", {nm, " retry gap"}, int'(lg_t[i+1] - lg_t[i] >= GAP_T), 1);
   endtask

   initial begin
      int s;
      s = $urandom(32'd4417);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "req after reset", acc_req, 0);
      chk("R12", "done after reset", done, 0);
      chk("R12", "err after reset", err, 0);
      chk("R12", "mask after reset", dev_present, 0);
      run_case("both",      1, 1, 1, 1, 0, 3, 2, 0, 8'h08, 3000, 0);
      run_case("d0only",    1, 0, 1, 1, 0, 1, 0, 0, 8'h02, 3000, 0);
      run_case("noslave",   1, 1, 0, 1, 0, 0, 0, 0, 8'h0C, 3000, 0);   // R3
      run_case("nodev0",    0, 1, 1, 1, 0, 0, 0, 0, 8'h00, 3000, 0);   // R6
      run_case("sigfail",   1, 1, 1, 0, 0, 2, 1, 0, 8'h0A, 3000, 0);   // R7
      run_case("dev1gone",  1, 1, 1, 1, 1, 0, 0, 0, 8'h00, 3000, 0);   // R7
      run_case("timeout",   1, 1, 1, 1, 0, 0, 0, 1, 8'h00, 40,   0);   // R9
      run_case("restart",   1, 1, 1, 1, 0, 4, 3, 0, 8'h04, 3000, 1);   // R11
      for (int n = 0; n < 8; n++)
         run_case("random", ($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                  ($urandom % 5) == 0, $urandom_range(0, 4), $urandom_range(0, 4), 0,
                  8'($urandom), 3000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule